// File: doc/BRIEF.md
# Layered PRG-ROM bank mapper

This block translates a CPU address in the upper half of a 16-bit space ($8000-$FFFF) into a 25-bit program ROM address. The upper half is split into four 8 KiB windows. Each window gets a 12-bit bank number, which covers 32 MiB of ROM. The low 13 address bits pass through unchanged below that bank number. CPU addresses below $8000 are not served by the block. For those, a flag marks the ROM address as meaningless.

The bank number is built in four layers:
- an inner bank in the style of the common scanline-counting mapper, with two selectable windows and two fixed ones;
- a middle-bank overlay that replaces the inner bits a mask select removes, which lets several games share one region of a multicart;
- an outer bank in the top four bits, which is either common to all windows or set per window;
- an 11-bit relative offset that is added last, with the carry out of bit 11 dropped.

The CPU programs these layers through a byte-wide write bus. Each write takes effect from the clock edge that ends it. The translation itself is purely combinational.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset all configuration is zero. A read at $8000 or $A000 then maps to bank $000, a read at $C000 maps to bank $03E and a read at $E000 maps to bank $03F.
- R2: For a CPU address with bit 15 clear, `unmapped` is 1. For bit 15 set, `unmapped` is 0, `rom_addr[12:0]` equals `cpu_addr[12:0]` and `rom_addr[24:13]` is the bank of the window that `cpu_addr[14:13]` selects.
- R3: With no swap, the inner value of window 0 ($8000) comes from register $4107 and that of window 1 ($A000) from $4108. Window 3 ($E000) always uses inner value $FF.
- R4: When bit 6 of $4105 is set, windows 0 and 2 exchange their inner sources and their outer sources. Windows 1 and 3 are unaffected.
- R5: Bit 6 of $410B set makes the window 2 source take its inner value from $4109. With that bit clear, the window 2 source uses $FE.
- R6: Bits 2:0 of $410B pick the inner mask: 0..7 give $3F,$1F,$0F,$07,$03,$01,$00,$FF. The low eight bank bits are (inner AND mask) OR ($410A AND NOT mask).
- R7: Bits 7:4 of $4100 form bank bits 11:8 for every window while per-window outer mode is off.
- R8: With bit 5 of $411C set, the outer sources change. Window 0 uses $4110[3:0] and window 1 uses $4110[7:4]. The window 2 source uses $4111[3:0] if $410B bit 6 is set, and $4100[7:4] otherwise. Window 3 keeps $4100[7:4].
- R9: {$4128[2:0], $4127} is added to the 12-bit combined bank and the result is kept modulo 4096. Bits 7:3 of $4128 are ignored.
- R10: With parameter EXTENDED = 0, bit 5 of $411C has no effect and the relative offset is treated as zero.
- R11: A register changes only on a clock edge where `wr_en` is 1. Its new value shows at the output only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 25 | Bank number concatenated with cpu_addr[12:0] |
| unmapped | output | 1 | CPU address lies below $8000; rom_addr is don't-care |

## Verification
The assertions check four things on every cycle:
- that low addresses raise the unmapped flag;
- that the 13 offset bits pass through;
- that the top window shows every bit its inner mask keeps set to one, and carries the common outer nibble, whenever no relative offset applies;
- that the configuration stays stable on cycles without a write.

Some behaviour can only be shown by the directed scenarios:
- the exact bank values under swap, third-window enable, each mask select and per-window outer mode;
- the relative add with its wrap-around;
- the difference between the legacy and extended variants.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int CPU_AW  = 16;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 12;
    localparam int OFFS_W  = 13;
    localparam int ROM_AW  = BANK_W + OFFS_W;
    localparam int OUTER_W = BANK_W - DATA_W;
    localparam int REL_W   = BANK_W - 1;
    localparam int NUM_WIN = 4;

    // Register addresses (software-visible map)
    localparam logic [CPU_AW-1:0] A_OUTER_ALL = 16'h4100;
    localparam logic [CPU_AW-1:0] A_SWAP      = 16'h4105;
    localparam logic [CPU_AW-1:0] A_INNER_0   = 16'h4107;
    localparam logic [CPU_AW-1:0] A_INNER_1   = 16'h4108;
    localparam logic [CPU_AW-1:0] A_INNER_2   = 16'h4109;
    localparam logic [CPU_AW-1:0] A_MID_VAL   = 16'h410A;
    localparam logic [CPU_AW-1:0] A_LAYOUT    = 16'h410B;
    localparam logic [CPU_AW-1:0] A_OUTER_01  = 16'h4110;
    localparam logic [CPU_AW-1:0] A_OUTER_2   = 16'h4111;
    localparam logic [CPU_AW-1:0] A_EXT_CTL   = 16'h411C;
    localparam logic [CPU_AW-1:0] A_REL_LO    = 16'h4127;
    localparam logic [CPU_AW-1:0] A_REL_HI    = 16'h4128;

    typedef struct packed {
        logic [OUTER_W-1:0] outer_all;
        logic               swap;
        logic [DATA_W-1:0]  inner_0;
        logic [DATA_W-1:0]  inner_1;
        logic [DATA_W-1:0]  inner_2;
        logic [DATA_W-1:0]  mid_val;
        logic [2:0]         mask_sel;
        logic               win2_en;
        logic [OUTER_W-1:0] outer_0;
        logic [OUTER_W-1:0] outer_1;
        logic [OUTER_W-1:0] outer_2;
        logic               split_outer;
        logic [DATA_W-1:0]  rel_lo;
        logic [REL_W-DATA_W-1:0] rel_hi;
    } cfg_t;

    function automatic logic [DATA_W-1:0] inner_mask(input logic [2:0] sel);
        if (sel == 3'd7) return 8'hFF;
        return 8'h3F >> sel;
    endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_OUTER_ALL: cfg_d.outer_all   = wr_data[7:4];
                A_SWAP:      cfg_d.swap        = wr_data[6];
                A_INNER_0:   cfg_d.inner_0     = wr_data;
                A_INNER_1:   cfg_d.inner_1     = wr_data;
                A_INNER_2:   cfg_d.inner_2     = wr_data;
                A_MID_VAL:   cfg_d.mid_val     = wr_data;
                A_LAYOUT: begin
                    cfg_d.mask_sel = wr_data[2:0];
                    cfg_d.win2_en  = wr_data[6];
                end
                A_OUTER_01: begin
                    cfg_d.outer_0 = wr_data[3:0];
                    cfg_d.outer_1 = wr_data[7:4];
                end
                A_OUTER_2:   cfg_d.outer_2     = wr_data[3:0];
                A_EXT_CTL:   cfg_d.split_outer = wr_data[5];
                A_REL_LO:    cfg_d.rel_lo      = wr_data;
                A_REL_HI:    cfg_d.rel_hi      = wr_data[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/prg_map_lane.sv
module prg_map_lane
    import prg_map_pkg::*;
#(
    parameter int LANE     = 0,
    parameter bit EXTENDED = 1'b1
) (
    input  cfg_t              cfg,
    output logic [BANK_W-1:0] bank
);

    logic [1:0]         src;
    logic               split;
    logic [DATA_W-1:0]  inner;
    logic [OUTER_W-1:0] outer;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  low;
    logic [REL_W-1:0]   rel;

    always_comb begin
        // Windows 0 and 2 trade sources when the swap bit is set
        if (cfg.swap && (LANE % 2 == 0)) src = 2'(LANE ^ 2);
        else                             src = 2'(LANE);

        split = EXTENDED && cfg.split_outer;

        case (src)
            2'd0: begin
                inner = cfg.inner_0;
                outer = split ? cfg.outer_0 : cfg.outer_all;
            end
            2'd1: begin
                inner = cfg.inner_1;
                outer = split ? cfg.outer_1 : cfg.outer_all;
            end
            2'd2: begin
                inner = cfg.win2_en ? cfg.inner_2 : 8'hFE;
                outer = (split && cfg.win2_en) ? cfg.outer_2 : cfg.outer_all;
            end
            default: begin
                inner = 8'hFF;
                outer = cfg.outer_all;
            end
        endcase

        mask = inner_mask(cfg.mask_sel);
        low  = (inner & mask) | (cfg.mid_val & ~mask);
        rel  = EXTENDED ? {cfg.rel_hi, cfg.rel_lo} : '0;
        bank = {outer, low} + {1'b0, rel};
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              unmapped
);

    cfg_t              cfg_q;
    logic [BANK_W-1:0] lane_bank [NUM_WIN];
    logic [1:0]        win;

    prg_map_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_lane
        prg_map_lane #(.LANE(g), .EXTENDED(EXTENDED)) u_lane (
            .cfg  (cfg_q),
            .bank (lane_bank[g])
        );
    end

    always_comb begin
        win      = cpu_addr[OFFS_W+1:OFFS_W];
        rom_addr = {lane_bank[win], cpu_addr[OFFS_W-1:0]};
        unmapped = !cpu_addr[CPU_AW-1];
    end

endmodule

// File: rtl/prg_map_checker.sv
module prg_map_checker
    import prg_map_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              unmapped,
    input cfg_t              cfg
);

    logic             rel_zero;
    logic [DATA_W-1:0] keep;
    logic             top_win;

    always_comb begin
        rel_zero = !EXTENDED || ({cfg.rel_hi, cfg.rel_lo} == '0);
        keep     = inner_mask(cfg.mask_sel);
        top_win  = (cpu_addr[CPU_AW-1:OFFS_W] == 3'b111) && rel_zero;
    end

    AST_BELOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[CPU_AW-1] |-> unmapped); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !unmapped |-> (rom_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0])); // R2

    AST_TOP_WINDOW_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        top_win |-> ((rom_addr[OFFS_W+DATA_W-1:OFFS_W] | ~keep) == 8'hFF)); // R3

    AST_TOP_WINDOW_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
        top_win |-> (rom_addr[ROM_AW-1:OFFS_W+DATA_W] == cfg.outer_all)); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg)); // R11

endmodule

bind prg_bank_mapper prg_map_checker #(.EXTENDED(EXTENDED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr),
    .unmapped (unmapped),
    .cfg      (cfg_q)
);

// File: tb/test_prg_bank_mapper.sv
`timescale 1ns/1ps
module test_prg_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [24:0] rom_addr, rom_addr_leg;
    logic        unmapped, unmapped_leg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prg_bank_mapper #(.EXTENDED(1'b1)) i_prg_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr),
        .rom_addr(rom_addr), .unmapped(unmapped)
    );

    prg_bank_mapper #(.EXTENDED(1'b0)) i_prg_bank_mapper_legacy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr),
        .rom_addr(rom_addr_leg), .unmapped(unmapped_leg)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [15:0] a, input logic [11:0] exp_bank, input string tag);
        logic [24:0] exp;
        cpu_addr = a;
        #1;
        exp = {exp_bank, a[12:0]};
        n_chk++;
        if (rom_addr !== exp || unmapped !== 1'b0) begin
            n_fail++;
            $display("FAIL %s addr=%h rom=%h unm=%b expected rom=%h unm=0",
                     tag, a, rom_addr, unmapped, exp);
        end
    endtask

    task automatic chk_leg(input logic [15:0] a, input logic [11:0] exp_bank, input string tag);
        logic [24:0] exp;
        cpu_addr = a;
        #1;
        exp = {exp_bank, a[12:0]};
        n_chk++;
        if (rom_addr_leg !== exp) begin
            n_fail++;
            $display("FAIL %s legacy addr=%h rom=%h expected %h", tag, a, rom_addr_leg, exp);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(16'h8000, 12'h000, "R1 win0");
        chk(16'hA000, 12'h000, "R1 win1");
        chk(16'hC000, 12'h03E, "R1 win2");
        chk(16'hE000, 12'h03F, "R1 win3");
        cpu_addr = 16'h6123;
        #1;
        n_chk++;
        if (unmapped !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 unmapped=%b expected 1", unmapped);
        end
        chk(16'hFFFF, 12'h03F, "R2 offset");
    endtask

    task automatic t_inner();
        do_reset();
        wr(16'h4107, 8'h05);
        wr(16'h4108, 8'h0A);
        chk(16'h8000, 12'h005, "R3 win0");
        chk(16'hA123, 12'h00A, "R3 win1");
        chk(16'hE456, 12'h03F, "R3 win3 fixed");
        // strobe low: no change (R11)
        @(negedge clk);
        wr_addr = 16'h4107; wr_data = 8'h77;
        @(negedge clk);
        chk(16'h8000, 12'h005, "R11 no strobe");
        // strobe high: not visible before the edge
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h09;
        chk(16'h8000, 12'h005, "R11 before edge");
        @(negedge clk);
        wr_en = 1'b0;
        chk(16'h8000, 12'h009, "R11 after edge");
    endtask

    task automatic t_swap();
        do_reset();
        wr(16'h4107, 8'h05);
        wr(16'h4105, 8'h40);
        chk(16'h8000, 12'h03E, "R4 win0");
        chk(16'hA000, 12'h000, "R4 win1");
        chk(16'hC000, 12'h005, "R4 win2");
        chk(16'hE000, 12'h03F, "R4 win3");
    endtask

    task automatic t_third();
        do_reset();
        wr(16'h410B, 8'h40);
        wr(16'h4109, 8'h12);
        chk(16'hC000, 12'h012, "R5 win2");
        wr(16'h4105, 8'h40);
        chk(16'h8000, 12'h012, "R5 swapped win0");
        chk(16'hC000, 12'h000, "R5 swapped win2");
    endtask

    task automatic t_mask();
        do_reset();
        wr(16'h4107, 8'h05);
        wr(16'h410A, 8'hA8);
        wr(16'h410B, 8'h03);
        chk(16'h8000, 12'h0AD, "R6 sel3 win0");
        chk(16'hE000, 12'h0AF, "R6 sel3 win3");
        wr(16'h410B, 8'h07);
        chk(16'h8000, 12'h005, "R6 sel7 win0");
        chk(16'hE000, 12'h0FF, "R6 sel7 win3");
        wr(16'h410B, 8'h06);
        chk(16'h8000, 12'h0A8, "R6 sel6 win0");
        chk(16'hE000, 12'h0A8, "R6 sel6 win3");
    endtask

    task automatic t_outer();
        do_reset();
        wr(16'h4100, 8'h35);
        chk(16'h8000, 12'h300, "R7 win0");
        chk(16'hE000, 12'h33F, "R7 win3");
    endtask

    task automatic t_split();
        do_reset();
        wr(16'h4100, 8'h90);
        wr(16'h4110, 8'h21);
        wr(16'h4111, 8'h07);
        wr(16'h411C, 8'h20);
        chk(16'h8000, 12'h100, "R8 win0");
        chk(16'hA000, 12'h200, "R8 win1");
        chk(16'hC000, 12'h93E, "R8 win2 common");
        chk(16'hE000, 12'h93F, "R8 win3");
        chk_leg(16'h8000, 12'h900, "R10 win0");
        chk_leg(16'hA000, 12'h900, "R10 win1");
        wr(16'h410B, 8'h40);
        chk(16'hC000, 12'h700, "R8 win2 own");
        wr(16'h4105, 8'h40);
        chk(16'h8000, 12'h700, "R8 swapped win0");
        chk(16'hC000, 12'h100, "R8 swapped win2");
    endtask

    task automatic t_rel();
        do_reset();
        wr(16'h4127, 8'h10);
        wr(16'h4128, 8'h01);
        chk(16'h8000, 12'h110, "R9 win0");
        chk(16'hE000, 12'h14F, "R9 win3");
        chk_leg(16'h8000, 12'h000, "R10 no offset");
        wr(16'h410B, 8'h07);
        wr(16'h4100, 8'hF0);
        wr(16'h4127, 8'hFF);
        wr(16'h4128, 8'hFF);
        chk(16'hE000, 12'h7FE, "R9 wrap");
        chk_leg(16'hE000, 12'hFFF, "R10 wrap");
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_inner();
        t_swap();
        t_third();
        t_mask();
        t_outer();
        t_split();
        t_rel();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule